// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block holds one 32-bit register slot per hart and turns each slot into a level software-interrupt line. Harts use it for inter-processor signalling: one hart writes to another hart's slot, and that hart's interrupt output rises. The interrupt controller on the hart side samples the output. The slots sit in a small address window. The slot for hart `h` begins at byte offset `4*h`, and the window decodes exactly `NUM_HARTS` slots.

A static parameter, `SET_ONLY`, picks one of two variants.

- **Readable set/clear variant** (`SET_ONLY=0`): bit 0 of a slot is a pending flag. Software can write it to 1 or to 0 and can read it back. Reset clears every flag.
- **Set-only variant** (`SET_ONLY=1`): a write can only raise the line, and every read returns zero. The line drops only when the hart side pulses its `irq_clr` input. Reset does not touch the latched lines.

The request port takes address, write enable, size code and data. A read answers one cycle later on `rsp_valid`/`rsp_rdata`. Malformed or out-of-window accesses read zero and change nothing, and no error is signalled.

Top module: `swi_bank`

## Requirements
- R1: Slot `h` is decoded at byte address `4*h` for `h < NUM_HARTS`. Bits `ADDR_W-1:2` select the slot.
- R2: A valid word write with data bit 0 = 1 to slot `h` sets `sw_irq[h]` on the clock edge that accepts the request. Data bits 31:1 have no effect.
- R3: With `SET_ONLY=0`, a valid word write with data bit 0 = 0 to slot `h` clears `sw_irq[h]` on the accepting edge.
- R4: With `SET_ONLY=1`, a write with data bit 0 = 0 leaves every `sw_irq` bit unchanged.
- R5: A read request (`req_valid`=1, `req_write`=0) is answered on the next cycle with `rsp_valid`=1. `rsp_rdata` bits 31:1 are zero. With `SET_ONLY=0`, bit 0 of `rsp_rdata` is the pending flag of the addressed slot. `rsp_valid` is 0 in every cycle not preceded by a read request.
- R6: With `SET_ONLY=1`, every read returns `rsp_rdata`=0.
- R7: An access is valid only with size code 2 (word) and address bits 1:0 equal to 0. The size codes are 0 = byte, 1 = half, 2 = word, 3 = double. Any other access reads zero and has no write effect.
- R8: An access whose slot index is `NUM_HARTS` or more reads zero and has no write effect. No error is raised.
- R9: With `SET_ONLY=0`, a clock edge with `rst_n`=0 clears all `sw_irq` bits and `rsp_valid`.
- R10: With `SET_ONLY=1`, reset leaves the `sw_irq` bits unchanged.
- R11: With `SET_ONLY=1`, `irq_clr[h]`=1 clears `sw_irq[h]` on the next edge. A set write to the same hart in the same cycle wins, and the line stays high.
- R12: With `SET_ONLY=0`, `irq_clr` has no effect.
- R13: A write changes only the addressed hart's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| irq_clr | input | NUM_HARTS | Per-hart clear pulse (set-only variant) |
| sw_irq | output | NUM_HARTS | Per-hart software interrupt level |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |

## Verification
The assertions assume that all inputs are two-state and change only between clock edges. They also assume that the set-only variant has had its latched lines defined by an `irq_clr` pulse, because reset does not reach those lines. The stimulus drives every input on the falling edge and holds `irq_clr` high throughout the first reset. Each stability property applies only in cycles where `irq_clr` is low, so that a clear landing in the same cycle as a malformed or zero-valued write is not mistaken for a write effect.

// File: rtl/swi_pkg.sv
package swi_pkg;

   localparam int unsigned SWI_DATA_W = 32;

   typedef enum logic [1:0] {
      SWI_SZ_BYTE  = 2'd0,
      SWI_SZ_HALF  = 2'd1,
      SWI_SZ_WORD  = 2'd2,
      SWI_SZ_DWORD = 2'd3
   } swi_size_e;

   // Narrowest address that still leaves one index bit beyond the slots,
   // so out-of-window slots stay distinguishable.
   function automatic int unsigned swi_min_addr_w(input int unsigned harts);
      return ((harts > 1) ? $clog2(harts) : 1) + 3;
   endfunction

endpackage

// File: rtl/swi_decode.sv
module swi_decode
   import swi_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 6,
   localparam int unsigned IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
   localparam int unsigned SLOT_W   = ADDR_W - 2
) (
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [1:0]           req_size,
   output logic [NUM_HARTS-1:0] wr_sel,
   output logic                 rd_hit,
   output logic [IDX_W-1:0]     rd_idx
);

   logic [SLOT_W-1:0] slot;
   logic              in_window;
   logic              well_formed;

   assign slot        = req_addr[ADDR_W-1:2];
   assign in_window   = 32'(slot) < NUM_HARTS;
   assign well_formed = (req_size == SWI_SZ_WORD) && (req_addr[1:0] == 2'b00) && in_window;

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
      assign wr_sel[h] = req_valid && req_write && well_formed && (slot == SLOT_W'(h));
   end

   assign rd_hit = req_valid && !req_write && well_formed;
   assign rd_idx = slot[IDX_W-1:0];

endmodule

// File: rtl/swi_slot.sv
module swi_slot #(
   parameter bit SET_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic drop_i,
   output logic pend_o
);

   // Set has priority over drop, so a fresh request is never lost.
   // The set-only variant ignores reset.
   always_ff @(posedge clk) begin
      if (!rst_n && !SET_ONLY) begin
         pend_o <= 1'b0;
      end else if (set_i) begin
         pend_o <= 1'b1;
      end else if (drop_i) begin
         pend_o <= 1'b0;
      end
   end

endmodule

// File: rtl/swi_bank.sv
module swi_bank
   import swi_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned MAX_HARTS = 4095,
   parameter int unsigned ADDR_W    = 6,
   parameter bit          SET_ONLY  = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [1:0]            req_size,
   input  logic [SWI_DATA_W-1:0] req_wdata,
   input  logic [NUM_HARTS-1:0]  irq_clr,
   output logic [NUM_HARTS-1:0]  sw_irq,
   output logic                  rsp_valid,
   output logic [SWI_DATA_W-1:0] rsp_rdata
);

   localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

   if (NUM_HARTS < 1 || NUM_HARTS > MAX_HARTS) begin : g_chk_harts
      $error("swi_bank: NUM_HARTS out of range");
   end
   if (ADDR_W < swi_min_addr_w(NUM_HARTS) || ADDR_W > 32) begin : g_chk_addr
      $error("swi_bank: ADDR_W too narrow or too wide");
   end

   logic [NUM_HARTS-1:0] wr_sel;
   logic                 rd_hit;
   logic [IDX_W-1:0]     rd_idx;
   logic [NUM_HARTS-1:0] pend;
   logic                 unused_wdata;

   assign unused_wdata = ^req_wdata[SWI_DATA_W-1:1];

   swi_decode #(
      .NUM_HARTS (NUM_HARTS),
      .ADDR_W    (ADDR_W)
   ) i_decode (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .wr_sel    (wr_sel),
      .rd_hit    (rd_hit),
      .rd_idx    (rd_idx)
   );

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic set_h;
      logic drop_h;
      assign set_h  = wr_sel[h] & req_wdata[0];
      assign drop_h = SET_ONLY ? irq_clr[h] : (wr_sel[h] & ~req_wdata[0]);
      swi_slot #(
         .SET_ONLY (SET_ONLY)
      ) i_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_h),
         .drop_i (drop_h),
         .pend_o (pend[h])
      );
   end

   assign sw_irq = pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= {{(SWI_DATA_W-1){1'b0}}, rd_hit && !SET_ONLY && pend[rd_idx]};
      end
   end

endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 6,
   parameter bit          SET_ONLY  = 1'b0,
   localparam int unsigned IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [ADDR_W-1:0]    req_addr,
   input logic [1:0]           req_size,
   input logic [31:0]          req_wdata,
   input logic [NUM_HARTS-1:0] irq_clr,
   input logic [NUM_HARTS-1:0] sw_irq,
   input logic                 rsp_valid,
   input logic [31:0]          rsp_rdata
);

   logic             malformed;
   logic             outside;
   logic [IDX_W-1:0] slot_lo;
   logic             started = 1'b0;
   logic             rst_seen;

   assign malformed = (req_size != 2'd2) || (req_addr[1:0] != 2'b00);
   assign outside   = 32'(req_addr[ADDR_W-1:2]) >= NUM_HARTS;
   assign slot_lo   = req_addr[IDX_W+1:2];

   always_ff @(posedge clk) begin
      started  <= 1'b1;
      rst_seen <= rst_n;
   end

   assert_read_answered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> rsp_valid);
   assert_no_spurious_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);
   assert_upper_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_rdata[31:1] == '0);
   assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_wdata[0] && !malformed && !outside |=> sw_irq[$past(slot_lo)]);
   assert_malformed_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && malformed && irq_clr == '0 |=> $stable(sw_irq));
   assert_outside_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && outside && irq_clr == '0 |=> $stable(sw_irq));

   if (SET_ONLY) begin : g_so
      assert_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> rsp_rdata == '0);
      assert_zero_write_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && req_write && !req_wdata[0] && irq_clr == '0 |=> $stable(sw_irq));
      assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
         irq_clr != '0 && !(req_valid && req_write) |=> (sw_irq & $past(irq_clr)) == '0);
   end else begin : g_rw
      assert_clear_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> $stable(sw_irq));
      always @(posedge clk) begin
         if (started && !rst_seen) begin
            assert_reset_clears_R9: assert (sw_irq == '0 && !rsp_valid)
               else $error("reset did not clear lines");
         end
      end
   end

endmodule

bind swi_bank swi_bank_chk #(
   .NUM_HARTS (NUM_HARTS),
   .ADDR_W    (ADDR_W),
   .SET_ONLY  (SET_ONLY)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_size  (req_size),
   .req_wdata (req_wdata),
   .irq_clr   (irq_clr),
   .sw_irq    (sw_irq),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata)
);

// File: tb/test_swi_bank.sv
module test_swi_bank;

   localparam int unsigned NH = 4;
   localparam int unsigned AW = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_write;
   logic [AW-1:0] req_addr;
   logic [1:0]    req_size;
   logic [31:0]   req_wdata;
   logic [NH-1:0] irq_clr;
   logic [NH-1:0] irq_m, irq_s;
   logic          rv_m, rv_s;
   logic [31:0]   rd_m, rd_s;

   logic [NH-1:0] exp_m, exp_s;
   logic [31:0]   q_m[$];
   logic [31:0]   q_s[$];
   int            total = 0;
   int            bad   = 0;

   always #4 clk = ~clk;   // 125 MHz

   swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SET_ONLY(1'b0)) i_swi_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .irq_clr(irq_clr), .sw_irq(irq_m), .rsp_valid(rv_m), .rsp_rdata(rd_m));

   swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SET_ONLY(1'b1)) i_swi_bank_so (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .irq_clr(irq_clr), .sw_irq(irq_s), .rsp_valid(rv_s), .rsp_rdata(rd_s));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops expected read data as responses appear (R5, R6, R7, R8).
   always @(negedge clk) begin
      if (rst_n && rv_m) begin
         if (q_m.size() == 0) check("R5 unexpected rsp rw", 32'h1, 32'h0);
         else check("R5 rw read data", rd_m, q_m.pop_front());
      end
      if (rst_n && rv_s) begin
         if (q_s.size() == 0) check("R6 unexpected rsp so", 32'h1, 32'h0);
         else check("R6 so read data", rd_s, q_s.pop_front());
      end
   end

   // Driver: one access (or idle) per cycle, updates the model, then checks lines.
   task automatic cycle(input string req, input logic vld, input logic wr, input logic [AW-1:0] a,
                        input logic [1:0] sz, input logic [31:0] d, input logic [NH-1:0] clr);
      logic [3:0] idx;
      logic       ok;
      idx = a[AW-1:2];
      ok  = vld && sz == 2'd2 && a[1:0] == 2'b00 && idx < NH;
      req_valid = vld; req_write = wr; req_addr = a; req_size = sz;
      req_wdata = d; irq_clr = clr;
      if (vld && !wr) begin
         q_m.push_back(ok ? {31'b0, exp_m[idx[1:0]]} : 32'h0);
         q_s.push_back(32'h0);
      end
      for (int h = 0; h < NH; h++) begin
         logic hit;
         hit = ok && wr && idx == h;
         if (hit) exp_m[h] = d[0];
         if (hit && d[0]) exp_s[h] = 1'b1;
         else if (clr[h]) exp_s[h] = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; irq_clr = '0;
      check({req, " rw lines"}, 32'(irq_m), 32'(exp_m));
      check({req, " so lines"}, 32'(irq_s), 32'(exp_s));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check("watchdog", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
      req_size = 2'd2; req_wdata = '0; irq_clr = '1;
      exp_m = '0; exp_s = '0;
      repeat (3) @(negedge clk);
      irq_clr = '0;
      rst_n = 1'b1;
      check("R9 reset lines rw", 32'(irq_m), 32'h0);
      check("R9 reset rsp_valid", 32'(rv_m), 32'h0);
      check("R11 clear during reset so", 32'(irq_s), 32'h0);

      cycle("R2 R1 R13 set hart0", 1, 1, 6'd0,  2'd2, 32'hA5A5_A5A5, 4'h0);
      cycle("R2 R13 set hart3",    1, 1, 6'd12, 2'd2, 32'h0000_0001, 4'h0);
      cycle("R1 R5 read hart0",    1, 0, 6'd0,  2'd2, 32'h0, 4'h0);
      cycle("R1 R5 read hart1",    1, 0, 6'd4,  2'd2, 32'h0, 4'h0);
      cycle("R5 read hart3",       1, 0, 6'd12, 2'd2, 32'h0, 4'h0);
      cycle("R8 read outside",     1, 0, 6'd20, 2'd2, 32'h0, 4'h0);
      cycle("R8 write outside",    1, 1, 6'd20, 2'd2, 32'h1, 4'h0);
      cycle("R8 write top slot",   1, 1, 6'd60, 2'd2, 32'h1, 4'h0);
      cycle("R3 R4 zero hart0",    1, 1, 6'd0,  2'd2, 32'hFFFF_FFFE, 4'h0);
      cycle("R5 read hart0 after", 1, 0, 6'd0,  2'd2, 32'h0, 4'h0);
      cycle("R7 misaligned write", 1, 1, 6'd5,  2'd2, 32'h1, 4'h0);
      cycle("R7 byte write",       1, 1, 6'd4,  2'd0, 32'h1, 4'h0);
      cycle("R7 double write",     1, 1, 6'd4,  2'd3, 32'h1, 4'h0);
      cycle("R7 half zero write",  1, 1, 6'd12, 2'd1, 32'h0, 4'h0);
      cycle("R7 double read",      1, 0, 6'd12, 2'd3, 32'h0, 4'h0);
      cycle("R7 misaligned read",  1, 0, 6'd14, 2'd2, 32'h0, 4'h0);
      cycle("R11 R12 clear hart3", 0, 0, 6'd0,  2'd2, 32'h0, 4'h8);
      cycle("R11 set wins hart1",  1, 1, 6'd4,  2'd2, 32'h1, 4'h2);
      cycle("R11 clear with read", 1, 0, 6'd4,  2'd2, 32'h0, 4'h1);
      cycle("R13 set hart2",       1, 1, 6'd8,  2'd2, 32'h1, 4'h0);
      cycle("R5 idle",             0, 0, 6'd0,  2'd2, 32'h0, 4'h0);

      // Reset with lines high: rw clears, so keeps its lines (R9, R10).
      rst_n = 1'b0;
      exp_m = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R9 reset clears rw", 32'(irq_m), 32'h0);
      check("R10 reset keeps so", 32'(irq_s), 32'(exp_s));
      cycle("R5 read after reset", 1, 0, 6'd8, 2'd2, 32'h0, 4'h0);
      cycle("R11 final clear",     0, 0, 6'd0, 2'd2, 32'h0, 4'hF);
      @(negedge clk);
      check("R5 all responses seen rw", 32'(q_m.size()), 32'h0);
      check("R6 all responses seen so", 32'(q_s.size()), 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule